// File: doc/BRIEF.md
# Busy-Acknowledge Serial Slave

This block is a byte-oriented serial slave for a two-wire-plus-clock link with no select line. The bus clock idles high. Both ends change data when the clock falls and sample it when the clock rises, and every bit is sent most-significant first. The slave has nothing to mark the start of a frame, so it finds byte boundaries by counting rising edges. If the clock stays high too long in the middle of a byte, the slave drops the partial byte.

After the eighth rising edge the slave lets go of its data line. A little later it pulls the shared clock line low as an acknowledge/busy signal. The received byte leaves the block on a one-cycle strobe at the moment this pull starts. The pull lasts a minimum time and is stretched for as long as no transmit byte is waiting. When the pull ends, the waiting byte moves into the shifter and becomes the next byte sent. All timing values are parameters counted in system-clock cycles.

The bus inputs pass through a two-stage synchronizer. The clock line is open-drain: `sclk_pull` high means the slave drives the line low. Receive data has no back-pressure: the consumer must take `rx_data` in the cycle `rx_valid` is high. Transmit data uses a valid/ready handshake into a one-entry holding register. A byte transfers in any cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low until that byte has moved into the shifter.

Top module: `busy_ack_serial_slave`

## Requirements
- R1: Reset state: `sclk_pull` is 0, `sdo_oe` is 0, `sdo` is 1, `tx_ready` is 1 and `rx_valid` is 0. The first byte sent after reset is the parameter TX_RESET (all ones by default).
- R2: The bits sampled on eight counted rising edges form the received byte, with the first bit as bit 7. This byte appears on `rx_data` together with a single-cycle `rx_valid`, in the same cycle that `sclk_pull` first goes high.
- R3: On each counted falling edge the slave drives the next bit of its current transmit byte on `sdo`, starting from bit 7. The master sees this bit on the rising edge that follows.
- R4: `sdo_oe` goes high at the first counted falling edge of a byte. It goes low T_REL+2 clock edges after the edge that first samples the eighth rise, and it is low whenever `sclk_pull` is high.
- R5: `sclk_pull` goes high T_ACK+2 clock edges after the edge that first samples the eighth rise. When a transmit byte is already waiting, the pull lasts exactly T_BUSY cycles.
- R6: When no transmit byte is waiting once T_BUSY has elapsed, `sclk_pull` stays high. It is released in the first cycle in which a byte is held.
- R7: A transmit byte is accepted in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until the pull is released, and it is high again in the cycle the release takes effect.
- R8: The byte accepted before a release is the byte sent in the following frame.
- R9: If the clock stays high for T_IDLE cycles with between one and seven bits of a byte counted, the partial byte is discarded, `sdo_oe` goes low, and the next frame sends the current transmit byte again from bit 7.
- R10: The falling and rising edges caused by the slave's own pull and release are not counted as bits. The byte count equals the number of frames the master sent.
- R11: Operation is correct at any clock half-period of at least four system cycles and below T_IDLE, covering both the slow and the fast bus rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Level of the shared bus clock line |
| sclk_pull | output | 1 | High: drive the bus clock line low |
| sdi | input | 1 | Data from master |
| sdo | output | 1 | Data to master |
| sdo_oe | output | 1 | Output enable for `sdo` |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | DW | Received byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | DW | Transmit byte |

## Verification
Frames run at a fast half-period of 6 cycles and a slow half-period of 25 cycles, which separates rate-independent framing from a design that depends on a particular bit period. Some transmit bytes are loaded before the acknowledge starts and one is loaded long after it. The first case shows the pull at its exact minimum width; the second shows the stretch and its release. A three-bit fragment followed by a long high clock shows whether the idle timeout discards the partial byte and restarts the transmit byte, rather than joining the fragment to the next frame. The byte patterns A5, 5A, C3, FF and 00 expose bit-order and stuck-bit faults. A cycle-accurate model compares every output on every clock.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [1:0] {
    PH_SHIFT = 2'd0,
    PH_HOLD  = 2'd1,
    PH_BUSY  = 2'd2,
    PH_GUARD = 2'd3
  } bss_phase_e;
endpackage

// File: rtl/bss_sync.sv
// Two-stage synchronizer per bit; resets to the idle-high bus level.
module bss_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        stab_q <= 1'b1;
      end else begin
        meta_q <= din[g];
        stab_q <= meta_q;
      end
    end
    assign lvl[g] = stab_q;
  end
endmodule

// File: rtl/bss_edge.sv
// Edge detector on a synchronized level.
module bss_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/bss_txhold.sv
// One-entry transmit holding register with valid/ready intake.
module bss_txhold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);
  logic accept;
  assign in_ready = ~full;
  assign accept   = in_valid & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (accept) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/bss_ctrl.sv
// Bit framing, acknowledge timing and shift registers.
module bss_ctrl
  import bss_pkg::*;
#(
  parameter int             DW       = 8,
  parameter int             T_REL    = 538,
  parameter int             T_ACK    = 1750,
  parameter int             T_BUSY   = 500,
  parameter int             T_IDLE   = 2500,
  parameter logic [DW-1:0]  TX_RESET = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_lvl,
  input  logic          clk_rise,
  input  logic          clk_fall,
  input  logic          dat_lvl,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  output logic          take,
  output logic          pull,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data
);
  localparam int CW   = (DW > 1) ? $clog2(DW) : 1;
  localparam int TMAX = (T_ACK > T_BUSY) ? T_ACK : T_BUSY;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int IW   = $clog2(T_IDLE + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
  localparam logic [TW-1:0] REL_AT   = TW'(T_REL - 1);
  localparam logic [TW-1:0] ACK_AT   = TW'(T_ACK - 1);
  localparam logic [TW-1:0] BUSY_AT  = TW'(T_BUSY - 1);
  localparam logic [IW-1:0] IDLE_AT  = IW'(T_IDLE - 1);

  bss_phase_e    ph;
  logic [CW-1:0] bit_cnt;
  logic [TW-1:0] tmr;
  logic [IW-1:0] idle;
  logic [DW-1:0] rx_sh, tx_cur, tx_aligned;
  logic          partial;

  assign partial    = (bit_cnt != '0);
  assign tx_aligned = tx_cur << bit_cnt;
  assign take       = (ph == PH_BUSY) && (tmr == BUSY_AT) && hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_SHIFT;
      bit_cnt  <= '0;
      tmr      <= '0;
      idle     <= '0;
      rx_sh    <= '0;
      tx_cur   <= TX_RESET;
      pull     <= 1'b0;
      sdo      <= 1'b1;
      sdo_oe   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (ph)
        PH_SHIFT: begin
          if (clk_rise) begin
            rx_sh <= {rx_sh[DW-2:0], dat_lvl};
            idle  <= '0;
            if (bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              tmr     <= '0;
              ph      <= PH_HOLD;
            end else begin
              bit_cnt <= bit_cnt + CW'(1);
            end
          end else if (clk_fall) begin
            sdo    <= tx_aligned[DW-1];
            sdo_oe <= 1'b1;
            idle   <= '0;
          end else if (partial && clk_lvl) begin
            if (idle == IDLE_AT) begin
              bit_cnt <= '0;
              sdo_oe  <= 1'b0;
              idle    <= '0;
            end else begin
              idle <= idle + IW'(1);
            end
          end else begin
            idle <= '0;
          end
        end
        PH_HOLD: begin
          tmr <= tmr + TW'(1);
          if (tmr == REL_AT) sdo_oe <= 1'b0;
          if (tmr == ACK_AT) begin
            ph       <= PH_BUSY;
            pull     <= 1'b1;
            rx_valid <= 1'b1;
            rx_data  <= rx_sh;
            tmr      <= '0;
          end
        end
        PH_BUSY: begin
          if (tmr != BUSY_AT) tmr <= tmr + TW'(1);
          if (take) begin
            pull   <= 1'b0;
            tx_cur <= hold_data;
            ph     <= PH_GUARD;
          end
        end
        PH_GUARD: begin
          if (clk_lvl) ph <= PH_SHIFT;
        end
        default: ph <= PH_SHIFT;
      endcase
    end
  end
endmodule

// File: rtl/busy_ack_serial_slave.sv
module busy_ack_serial_slave #(
  parameter int            DW       = 8,
  parameter int            T_REL    = 538,
  parameter int            T_ACK    = 1750,
  parameter int            T_BUSY   = 500,
  parameter int            T_IDLE   = 2500,
  parameter logic [DW-1:0] TX_RESET = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_in,
  output logic          sclk_pull,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data
);
  logic [1:0]    lvl;
  logic          c_rise, c_fall, take, hold_full;
  logic [DW-1:0] hold_data;

  bss_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sdi, sclk_in}), .lvl(lvl)
  );

  bss_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl[0]), .rise(c_rise), .fall(c_fall)
  );

  bss_txhold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(tx_valid), .in_ready(tx_ready),
    .in_data(tx_data), .take(take), .full(hold_full), .data(hold_data)
  );

  bss_ctrl #(
    .DW(DW), .T_REL(T_REL), .T_ACK(T_ACK), .T_BUSY(T_BUSY),
    .T_IDLE(T_IDLE), .TX_RESET(TX_RESET)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_lvl(lvl[0]), .clk_rise(c_rise),
    .clk_fall(c_fall), .dat_lvl(lvl[1]), .hold_full(hold_full),
    .hold_data(hold_data), .take(take), .pull(sclk_pull), .sdo(sdo),
    .sdo_oe(sdo_oe), .rx_valid(rx_valid), .rx_data(rx_data)
  );
endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
  parameter int T_BUSY = 500
) (
  input logic clk,
  input logic rst_n,
  input logic sclk_pull,
  input logic sdo_oe,
  input logic rx_valid,
  input logic tx_valid,
  input logic tx_ready
);
  logic [31:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_run <= '0;
    else if (sclk_pull) low_run <= low_run + 32'd1;
    else                low_run <= '0;
  end

  AST_VALID_WITH_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (sclk_pull && !$past(sclk_pull))); // R2
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R2
  AST_OE_QUIET_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_pull |-> !sdo_oe); // R4
  AST_BUSY_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_pull) |-> (low_run >= 32'(T_BUSY))); // R5
  AST_RELEASE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_pull) |-> tx_ready); // R6
  AST_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R7
endmodule

bind busy_ack_serial_slave bss_checker #(.T_BUSY(T_BUSY)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_pull(sclk_pull), .sdo_oe(sdo_oe),
  .rx_valid(rx_valid), .tx_valid(tx_valid), .tx_ready(tx_ready)
);

// File: tb/sim_busy_ack_serial_slave.sv
`timescale 1ns/1ps
module sim_busy_ack_serial_slave;
  localparam int P_REL = 10, P_ACK = 30, P_BUSY = 12, P_IDLE = 80;
  localparam int FAST = 6, SLOW = 25, GAP = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mclk = 1'b1, mosi = 1'b1;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic sclk_pull, sdo, sdo_oe, rx_valid, tx_ready;
  logic [7:0] rx_data;
  wire bus_clk = mclk & ~sclk_pull;

  always #4 clk = ~clk;

  busy_ack_serial_slave #(
    .DW(8), .T_REL(P_REL), .T_ACK(P_ACK), .T_BUSY(P_BUSY), .T_IDLE(P_IDLE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_in(bus_clk), .sclk_pull(sclk_pull),
    .sdi(mosi), .sdo(sdo), .sdo_oe(sdo_oe), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference, advanced on every rising system clock.
  bit qc[$], qd[$];
  int m_ph, m_cnt, m_tmr, m_idle, m_rx, m_tx, m_hold, m_rxd;
  bit m_have, m_pull, m_sdo, m_oe, m_rxv;
  bit ln, cur, prv, dd, acc;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_tmr = 0; m_idle = 0; m_rx = 0; m_tx = 255;
      m_hold = 0; m_rxd = 0; m_have = 0; m_pull = 0; m_sdo = 1; m_oe = 0;
      m_rxv = 0;
      qc = '{1, 1, 1, 1};
      qd = '{1, 1, 1, 1};
    end else begin
      ln = mclk & ~m_pull;
      qc.push_back(ln);   qc.delete(0);
      qd.push_back(mosi); qd.delete(0);
      cur = qc[1]; prv = qc[0]; dd = qd[1];
      acc = tx_valid && !m_have;
      m_rxv = 0;
      case (m_ph)
        0: begin
          if (cur && !prv) begin
            m_rx = ((m_rx << 1) | int'(dd)) & 255;
            m_idle = 0;
            if (m_cnt == 7) begin m_cnt = 0; m_tmr = 0; m_ph = 1; end
            else m_cnt++;
          end else if (!cur && prv) begin
            m_sdo = ((m_tx >> (7 - m_cnt)) & 1) != 0;
            m_oe = 1; m_idle = 0;
          end else if (m_cnt != 0 && cur) begin
            if (m_idle == P_IDLE - 1) begin m_cnt = 0; m_oe = 0; m_idle = 0; end
            else m_idle++;
          end else m_idle = 0;
        end
        1: begin
          if (m_tmr == P_REL - 1) m_oe = 0;
          if (m_tmr == P_ACK - 1) begin
            m_ph = 2; m_pull = 1; m_rxv = 1; m_rxd = m_rx; m_tmr = 0;
          end else m_tmr++;
        end
        2: begin
          if (m_tmr == P_BUSY - 1 && m_have) begin
            m_pull = 0; m_tx = m_hold; m_have = 0; m_ph = 3;
          end else if (m_tmr != P_BUSY - 1) m_tmr++;
        end
        default: if (cur) m_ph = 0;
      endcase
      if (acc) begin m_have = 1; m_hold = int'(tx_data); end
    end
  end

  // Per-cycle comparison and event monitor on the falling system clock.
  bit p_pull = 0, p_oe = 0;
  int pull_start = 0, oe_drop = 0, run_w = 0, last_w = 0;
  int rx_cnt = 0, last_rx = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(sclk_pull === m_pull, "R5", "sclk_pull", int'(sclk_pull), int'(m_pull));
      chk(sdo_oe === m_oe, "R4", "sdo_oe", int'(sdo_oe), int'(m_oe));
      chk(sdo === m_sdo, "R3", "sdo", int'(sdo), int'(m_sdo));
      chk(tx_ready === !m_have, "R7", "tx_ready", int'(tx_ready), int'(!m_have));
      chk(rx_valid === m_rxv, "R2", "rx_valid", int'(rx_valid), int'(m_rxv));
      if (m_rxv) chk(int'(rx_data) == m_rxd, "R2", "rx_data", int'(rx_data), m_rxd);
      if (sclk_pull && !p_pull) pull_start = cyc;
      if (!sdo_oe && p_oe) oe_drop = cyc;
      if (sclk_pull) run_w++;
      if (!sclk_pull && p_pull) begin last_w = run_w; run_w = 0; end
      if (rx_valid) begin rx_cnt++; last_rx = int'(rx_data); end
      p_pull = sclk_pull; p_oe = sdo_oe;
    end
  end

  int last_rise = 0;
  task automatic send_bits(input logic [7:0] b, input int nb, input int half,
                           output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nb; i++) begin
      mosi = b[7-i]; mclk = 1'b0;
      repeat (half) @(negedge clk);
      got[7-i] = sdo;
      mclk = 1'b1; last_rise = cyc;
      repeat (half) @(negedge clk);
    end
  endtask

  task automatic load(input logic [7:0] b);
    tx_data = b; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_ack();
    while (bus_clk !== 1'b0) @(negedge clk);
    while (bus_clk !== 1'b1) @(negedge clk);
    repeat (GAP) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected<100000", cyc);
      finish_run();
    end
  end

  logic [7:0] got;
  int rx_before;
  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sclk_pull == 1'b0, "R1", "pull at reset", int'(sclk_pull), 0);
    chk(sdo_oe == 1'b0, "R1", "oe at reset", int'(sdo_oe), 0);
    chk(sdo == 1'b1, "R1", "sdo at reset", int'(sdo), 1);
    chk(tx_ready == 1'b1, "R1", "ready at reset", int'(tx_ready), 1);

    // Fast frame, next byte waiting before the acknowledge (R5 exact timing).
    send_bits(8'hA5, 8, FAST, got);
    load(8'h3C);
    wait_ack();
    chk(got == 8'hFF, "R1", "first sent byte", int'(got), 'hFF);
    chk(last_rx == 'hA5, "R2", "rx byte fast", last_rx, 'hA5);
    chk(pull_start - last_rise == P_ACK + 3, "R5", "pull delay", pull_start - last_rise, P_ACK + 3);
    chk(oe_drop - last_rise == P_REL + 3, "R4", "oe release delay", oe_drop - last_rise, P_REL + 3);
    chk(last_w == P_BUSY, "R5", "busy width", last_w, P_BUSY);

    // Slow frame, no byte waiting: stretched acknowledge (R6, R8, R11).
    send_bits(8'h5A, 8, SLOW, got);
    chk(got == 8'h3C, "R8", "loaded byte sent", int'(got), 'h3C);
    while (bus_clk !== 1'b0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(sclk_pull == 1'b1, "R6", "pull held while empty", int'(sclk_pull), 1);
    load(8'h96);
    wait_ack();
    chk(last_w >= 40, "R6", "stretched width", last_w, 40);
    chk(tx_ready == 1'b1, "R7", "ready after release", int'(tx_ready), 1);
    chk(last_rx == 'h5A, "R11", "rx byte slow", last_rx, 'h5A);

    // Fragment then idle timeout (R9).
    rx_before = rx_cnt;
    send_bits(8'hE0, 3, FAST, got);
    repeat (P_IDLE + 40) @(negedge clk);
    chk(sdo_oe == 1'b0, "R9", "oe off after timeout", int'(sdo_oe), 0);
    chk(rx_cnt == rx_before, "R9", "no byte from fragment", rx_cnt, rx_before);
    load(8'h00);
    send_bits(8'hC3, 8, FAST, got);
    chk(got == 8'h96, "R9", "tx byte restarted", int'(got), 'h96);
    wait_ack();
    chk(last_rx == 'hC3, "R9", "rx after fragment", last_rx, 'hC3);

    // Extreme patterns at both rates.
    load(8'h81);
    send_bits(8'hFF, 8, SLOW, got);
    wait_ack();
    chk(got == 8'h00, "R3", "all-zero sent", int'(got), 0);
    chk(last_rx == 'hFF, "R2", "rx all ones", last_rx, 'hFF);
    load(8'h42);
    send_bits(8'h00, 8, FAST, got);
    wait_ack();
    chk(got == 8'h81, "R3", "pattern 81 sent", int'(got), 'h81);
    chk(last_rx == 0, "R2", "rx all zeros", last_rx, 0);
    chk(rx_cnt == 5, "R10", "byte count", rx_cnt, 5);
    finish_run();
  end
endmodule